// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

A small up/down counter with two separate count clocks. A rising edge on the up clock adds one to the count, and a rising edge on the down clock subtracts one. Each edge counts only while the other clock stays high. An active-low preset input copies a data word into the count. An active-high clear forces the count to zero and wins over the preset. A mode parameter picks plain binary counting (modulo 16) or decade counting (modulo 10). In decade mode, any code from 10 to 15 goes back to the 0 to 9 sequence after one count.

The two count clocks are treated as slow data signals sampled by a free-running system clock. Each one passes through a synchronizer and a rising-edge detector. Two active-low terminal-count outputs are provided:
- The carry output is low while the count sits at its maximum and the up clock is low.
- The borrow output is low while the count is zero and the down clock is low.

Each terminal-count output rises again at the edge that wraps the count. This lets one stage's carry and borrow outputs drive the up and down clocks of the next, more significant stage.

Top module: `updown_tc_counter`

## Requirements
- R1: A rising edge on `up_clk_i` while `dn_clk_i` is steadily high increments `count_o` by one. In binary mode 15 wraps to 0.
- R2: A rising edge on `dn_clk_i` while `up_clk_i` is steadily high decrements `count_o` by one. In binary mode 0 wraps to 15.
- R3: No count is made for a rising edge on one count clock while the other is low. No count is made when both clocks rise in the same system cycle.
- R4: While `load_n_i` is low, `count_o` takes the value of `preset_i` on every system clock edge, and count edges are ignored.
- R5: While `clear_i` is high, `count_o` becomes 0 on the next system clock edge, even when `load_n_i` is low.
- R6: `carry_n_o` is low exactly when the synchronized up-clock level is low and `count_o` equals the maximum (15 binary, 9 decade). Otherwise it is high.
- R7: `borrow_n_o` is low exactly when the synchronized down-clock level is low and `count_o` is 0. Otherwise it is high.
- R8: In decade mode (MODE = MODE_DEC) the count runs 0 to 9. Up from 9 or from any code 10 to 15 gives 0. Down from 0 or from any code 10 to 15 gives 9.
- R9: Each count clock passes through a two-flop synchronizer. An accepted count edge driven just after a falling system-clock edge appears on `count_o` after the third following rising system-clock edge.
- R10: Two units chained carry-to-up-clock and borrow-to-down-clock count as one 8-bit counter in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running system clock |
| rst_n | input | 1 | asynchronous active-low system reset |
| up_clk_i | input | 1 | count-up clock, acts on its rising edge |
| dn_clk_i | input | 1 | count-down clock, acts on its rising edge |
| load_n_i | input | 1 | active-low parallel preset |
| clear_i | input | 1 | active-high clear, highest priority |
| preset_i | input | CNT_W | preset data word |
| count_o | output | CNT_W | current count |
| carry_n_o | output | 1 | active-low terminal count in the up direction |
| borrow_n_o | output | 1 | active-low terminal count in the down direction |

## Verification
A binary unit and a decade unit receive the same stimulus:
- Sequences of up pulses and down pulses separate the two wrap points of each mode. Starting them from an illegal decade code shows the recovery step in each direction.
- Edges given while the other clock is low, and both clocks rising together, must leave the count unchanged. This tells the qualified-edge rule apart from a plain edge detector.
- Holding each clock low at 15, 9 and 0 shows which mode drives each terminal-count output.
- A two-stage chain that counts past two wraps up and then back across a borrow confirms that the terminal-count pulses make clean clock edges for the next stage.

// File: rtl/tc_counter_pkg.sv
package tc_counter_pkg;
   typedef enum logic {
      MODE_BIN = 1'b0,
      MODE_DEC = 1'b1
   } count_mode_e;

   localparam int DEC_LAST = 9;
endpackage

// File: rtl/clk_edge_sync.sv
module clk_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clk_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~last_q;

   assert_single_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/count_core.sv
module count_core #(
   parameter int                          CNT_W = 4,
   parameter tc_counter_pkg::count_mode_e MODE  = tc_counter_pkg::MODE_BIN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_rise,
   input  logic             up_lvl,
   input  logic             dn_rise,
   input  logic             dn_lvl,
   input  logic             load_n,
   input  logic             clear,
   input  logic [CNT_W-1:0] preset,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] nxt_up, nxt_dn;
   logic             inc, dec;

   assign inc = up_rise & dn_lvl & ~dn_rise;
   assign dec = dn_rise & up_lvl & ~up_rise;

   if (MODE == tc_counter_pkg::MODE_DEC) begin : g_decade
      localparam logic [CNT_W-1:0] LAST = CNT_W'(tc_counter_pkg::DEC_LAST);
      always_comb begin
         nxt_up = (cnt >= LAST) ? '0 : cnt + ONE;
         nxt_dn = (cnt == '0 || cnt > LAST) ? LAST : cnt - ONE;
      end
      assert_decade_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt <= LAST && load_n) |=> cnt <= LAST);
   end else begin : g_binary
      always_comb begin
         nxt_up = cnt + ONE;
         nxt_dn = cnt - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clear)   cnt <= '0;
      else if (!load_n) cnt <= preset;
      else if (inc)     cnt <= nxt_up;
      else if (dec)     cnt <= nxt_dn;
   end

   assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt == '0);
   assert_load_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && !clear) |=> cnt == $past(preset));
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !clear && !inc && !dec) |=> $stable(cnt));
endmodule

// File: rtl/term_count_gen.sv
module term_count_gen #(
   parameter int                          CNT_W = 4,
   parameter tc_counter_pkg::count_mode_e MODE  = tc_counter_pkg::MODE_BIN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             up_lvl,
   input  logic             dn_lvl,
   output logic             carry_n,
   output logic             borrow_n
);
   localparam logic [CNT_W-1:0] TOP_VAL = (MODE == tc_counter_pkg::MODE_DEC)
                                        ? CNT_W'(tc_counter_pkg::DEC_LAST) : '1;

   assign carry_n  = ~(~up_lvl & (cnt == TOP_VAL));
   assign borrow_n = ~(~dn_lvl & (cnt == '0));

   assert_carry_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(carry_n) |-> !up_lvl);
endmodule

// File: rtl/updown_tc_counter.sv
module updown_tc_counter #(
   parameter int                          CNT_W       = 4,
   parameter int                          SYNC_STAGES = 2,
   parameter tc_counter_pkg::count_mode_e MODE        = tc_counter_pkg::MODE_BIN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_clk_i,
   input  logic             dn_clk_i,
   input  logic             load_n_i,
   input  logic             clear_i,
   input  logic [CNT_W-1:0] preset_i,
   output logic [CNT_W-1:0] count_o,
   output logic             carry_n_o,
   output logic             borrow_n_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("updown_tc_counter: CNT_W must be at least 2");
   end
   if (MODE == tc_counter_pkg::MODE_DEC && CNT_W != 4) begin : g_bad_dec
      $error("updown_tc_counter: decade mode needs CNT_W of 4");
   end

   logic [1:0] lvl, rise;
   logic [1:0] raw_clk;

   assign raw_clk = {dn_clk_i, up_clk_i};

   for (genvar i = 0; i < 2; i++) begin : g_sync
      clk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (raw_clk[i]),
         .level_o (lvl[i]),
         .rise_o  (rise[i])
      );
   end

   count_core #(.CNT_W(CNT_W), .MODE(MODE)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .up_rise (rise[0]),
      .up_lvl  (lvl[0]),
      .dn_rise (rise[1]),
      .dn_lvl  (lvl[1]),
      .load_n  (load_n_i),
      .clear   (clear_i),
      .preset  (preset_i),
      .cnt     (count_o)
   );

   term_count_gen #(.CNT_W(CNT_W), .MODE(MODE)) u_tc (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (count_o),
      .up_lvl   (lvl[0]),
      .dn_lvl   (lvl[1]),
      .carry_n  (carry_n_o),
      .borrow_n (borrow_n_o)
   );

   assert_borrow_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !borrow_n_o |-> count_o == '0);
   assert_tc_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!carry_n_o && !borrow_n_o));
endmodule

// File: tb/updown_tc_counter_test.sv
`timescale 1ns/1ps
module tc_ref_model #(
   parameter bit DEC = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       up,
   input  logic       dn,
   input  logic       ld_n,
   input  logic       clr,
   input  logic [3:0] pre,
   output int         exp_cnt,
   output logic       exp_carry_n,
   output logic       exp_borrow_n
);
   int   top;
   logic u[3];
   logic d[3];
   initial top = DEC ? 9 : 15;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_cnt = 0;
         for (int k = 0; k < 3; k++) begin u[k] = 1'b1; d[k] = 1'b1; end
      end else begin
         bit ur, dr;
         ur = u[1] && !u[2];
         dr = d[1] && !d[2];
         if (clr) exp_cnt = 0;
         else if (!ld_n) exp_cnt = int'(pre);
         else if (ur && d[1] && !dr) exp_cnt = (exp_cnt >= top) ? 0 : exp_cnt + 1;
         else if (dr && u[1] && !ur) exp_cnt = (exp_cnt == 0 || exp_cnt > top) ? top : exp_cnt - 1;
         u[2] = u[1]; u[1] = u[0]; u[0] = up;
         d[2] = d[1]; d[1] = d[0]; d[0] = dn;
      end
      exp_carry_n  = !(!u[1] && exp_cnt == top);
      exp_borrow_n = !(!d[1] && exp_cnt == 0);
   end
endmodule

module updown_tc_counter_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up = 1'b1, dn = 1'b1, ld_n = 1'b1, clr = 1'b0;
   logic [3:0] pre = 4'd0;
   logic c_up = 1'b1, c_dn = 1'b1, c_clr = 1'b0;

   logic [3:0] b_cnt, d_cnt, lo_cnt, hi_cnt;
   logic b_cy, b_bw, d_cy, d_bw, lo_cy, lo_bw, hi_cy, hi_bw;
   int   mb_cnt, md_cnt;
   logic mb_cy, mb_bw, md_cy, md_bw;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string phase = "R4";

   always #2.5 clk = ~clk;

   updown_tc_counter uut (
      .clk(clk), .rst_n(rst_n), .up_clk_i(up), .dn_clk_i(dn), .load_n_i(ld_n),
      .clear_i(clr), .preset_i(pre), .count_o(b_cnt), .carry_n_o(b_cy), .borrow_n_o(b_bw));

   updown_tc_counter #(.MODE(tc_counter_pkg::MODE_DEC)) uut_dec (
      .clk(clk), .rst_n(rst_n), .up_clk_i(up), .dn_clk_i(dn), .load_n_i(ld_n),
      .clear_i(clr), .preset_i(pre), .count_o(d_cnt), .carry_n_o(d_cy), .borrow_n_o(d_bw));

   updown_tc_counter uut_lo (
      .clk(clk), .rst_n(rst_n), .up_clk_i(c_up), .dn_clk_i(c_dn), .load_n_i(1'b1),
      .clear_i(c_clr), .preset_i(4'd0), .count_o(lo_cnt), .carry_n_o(lo_cy), .borrow_n_o(lo_bw));

   updown_tc_counter uut_hi (
      .clk(clk), .rst_n(rst_n), .up_clk_i(lo_cy), .dn_clk_i(lo_bw), .load_n_i(1'b1),
      .clear_i(c_clr), .preset_i(4'd0), .count_o(hi_cnt), .carry_n_o(hi_cy), .borrow_n_o(hi_bw));

   tc_ref_model #(.DEC(1'b0)) ref_b (.clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .ld_n(ld_n),
      .clr(clr), .pre(pre), .exp_cnt(mb_cnt), .exp_carry_n(mb_cy), .exp_borrow_n(mb_bw));
   tc_ref_model #(.DEC(1'b1)) ref_d (.clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .ld_n(ld_n),
      .clr(clr), .pre(pre), .exp_cnt(md_cnt), .exp_carry_n(md_cy), .exp_borrow_n(md_bw));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the behavioural model.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(phase, "bin count", int'(b_cnt), mb_cnt);
         chk(phase, "dec count", int'(d_cnt), md_cnt);
         chk("R6", "bin carry_n", int'(b_cy), int'(mb_cy));
         chk("R6", "dec carry_n", int'(d_cy), int'(md_cy));
         chk("R7", "bin borrow_n", int'(b_bw), int'(mb_bw));
         chk("R7", "dec borrow_n", int'(d_bw), int'(md_bw));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic pulse_up(input int n);
      for (int i = 0; i < n; i++) begin up = 1'b0; cyc(4); up = 1'b1; cyc(4); end
   endtask
   task automatic pulse_dn(input int n);
      for (int i = 0; i < n; i++) begin dn = 1'b0; cyc(4); dn = 1'b1; cyc(4); end
   endtask
   task automatic load(input logic [3:0] v);
      pre = v; ld_n = 1'b0; cyc(2); ld_n = 1'b1; cyc(2);
   endtask
   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      int wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual %0d expected below 150000", wd);
            finish_run();
         end
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R1", "reset count", int'(b_cnt), 0);
      chk("R6", "reset carry_n", int'(b_cy), 1);
      chk("R7", "reset borrow_n", int'(b_bw), 1);

      // R4: load held while count edges arrive
      phase = "R4";
      pre = 4'd13; ld_n = 1'b0;
      up = 1'b0; cyc(4); up = 1'b1; cyc(4);
      dn = 1'b0; cyc(4); dn = 1'b1; cyc(4);
      chk("R4", "bin held load", int'(b_cnt), 13);
      chk("R4", "dec held load", int'(d_cnt), 13);
      ld_n = 1'b1; cyc(2);

      phase = "R1";
      pulse_up(5);
      chk("R1", "bin up wrap", int'(b_cnt), 2);
      chk("R8", "dec up from illegal", int'(d_cnt), 4);

      phase = "R2";
      pulse_dn(6);
      chk("R2", "bin down wrap", int'(b_cnt), 12);
      chk("R8", "dec down wrap", int'(d_cnt), 8);

      phase = "R3";
      up = 1'b0; cyc(4);
      pulse_dn(2);
      chk("R3", "bin dn while up low", int'(b_cnt), 12);
      chk("R3", "dec dn while up low", int'(d_cnt), 8);
      up = 1'b1; cyc(5);
      chk("R1", "bin up release counts", int'(b_cnt), 13);
      chk("R1", "dec up release counts", int'(d_cnt), 9);
      up = 1'b0; dn = 1'b0; cyc(4);
      up = 1'b1; dn = 1'b1; cyc(5);
      chk("R3", "bin both rise", int'(b_cnt), 13);
      chk("R3", "dec both rise", int'(d_cnt), 9);

      phase = "R5";
      clr = 1'b1; ld_n = 1'b0; pre = 4'd5; cyc(2);
      chk("R5", "bin clear over load", int'(b_cnt), 0);
      chk("R5", "dec clear over load", int'(d_cnt), 0);
      clr = 1'b0; ld_n = 1'b1; cyc(2);

      phase = "R6";
      load(4'd15);
      up = 1'b0; cyc(4);
      chk("R6", "bin carry at 15", int'(b_cy), 0);
      chk("R6", "dec carry at 15", int'(d_cy), 1);
      up = 1'b1; cyc(4);
      chk("R6", "bin carry released", int'(b_cy), 1);
      chk("R1", "bin 15 wraps", int'(b_cnt), 0);
      chk("R8", "dec 15 to 0", int'(d_cnt), 0);
      load(4'd9);
      up = 1'b0; cyc(4);
      chk("R6", "dec carry at 9", int'(d_cy), 0);
      chk("R6", "bin carry at 9", int'(b_cy), 1);
      up = 1'b1; cyc(4);
      chk("R8", "dec 9 to 0", int'(d_cnt), 0);
      chk("R6", "dec carry released", int'(d_cy), 1);

      phase = "R7";
      load(4'd0);
      dn = 1'b0; cyc(4);
      chk("R7", "bin borrow at 0", int'(b_bw), 0);
      chk("R7", "dec borrow at 0", int'(d_bw), 0);
      dn = 1'b1; cyc(4);
      chk("R7", "bin borrow released", int'(b_bw), 1);
      chk("R2", "bin 0 wraps", int'(b_cnt), 15);
      chk("R8", "dec 0 to 9", int'(d_cnt), 9);

      phase = "R8";
      load(4'd12);
      pulse_dn(1);
      chk("R2", "bin 12 down", int'(b_cnt), 11);
      chk("R8", "dec illegal down", int'(d_cnt), 9);

      phase = "R9";
      load(4'd3);
      up = 1'b0; cyc(4);
      up = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      chk("R9", "no count after two edges", int'(b_cnt), 3);
      @(posedge clk); #1;
      chk("R9", "count after third edge", int'(b_cnt), 4);
      cyc(4);

      // R10: two-stage chain
      c_clr = 1'b1; cyc(2); c_clr = 1'b0; cyc(2);
      for (int i = 0; i < 40; i++) begin c_up = 1'b0; cyc(4); c_up = 1'b1; cyc(4); end
      cyc(6);
      chk("R10", "chain up value", int'({hi_cnt, lo_cnt}), 40);
      for (int i = 0; i < 9; i++) begin c_dn = 1'b0; cyc(4); c_dn = 1'b1; cyc(4); end
      cyc(6);
      chk("R10", "chain down value", int'({hi_cnt, lo_cnt}), 31);

      finish_run();
   end
endmodule